// File: doc/BRIEF.md
# Effective Address Generator

This unit forms the effective address of a memory operand and places it into a destination register. The address is built from an optional base value, an optional index value scaled by 1, 2, 4 or 8, and a signed displacement. The sum wraps at the selected address width. The sum is then fitted to the destination register width, which is chosen independently of the address width.

Fitting follows three cases. If the register is narrower than the address, the upper part of the address is dropped. If the register is wider, the address is padded with zeros. If the two widths are equal, the address passes unchanged. A source operand that names a register, and not memory, produces an invalid-opcode fault and no write. An illegal width selector also produces the fault.

The result is registered, so it appears one cycle after the request. The unit has no flag outputs and changes no processor status. A pipeline uses it as a single-cycle execution stage.

Top module: `eag_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid`, `out_wr_en` and `out_fault` are 0 and `out_value` is 0.
- R2: `out_valid` is 1 in exactly the cycles that follow a cycle with `in_valid` at 1. In every other cycle `out_wr_en` and `out_fault` are 0.
- R3: The address is `base + (index << scale) + sign-extended disp`, taken modulo 2^N, where N is the address width. A base or index whose enable is 0 adds zero.
- R4: `scale` is a shift amount: code 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R5: When the address and register widths are equal, `out_value` is the address unchanged.
- R6: When the address width is larger than the register width, `out_value` holds only the low register-width bits of the address. The bits above are 0.
- R7: When the address width is smaller than the register width, the address is zero-extended to the register width.
- R8: A request with `src_is_reg` at 1 gives `out_fault` 1, `out_wr_en` 0 and `out_value` 0.
- R9: The width selectors encode 0 as 16 bits, 1 as 32 bits and 2 as 64 bits. Code 3 on either selector raises `out_fault` and suppresses the write, as in R8.
- R10: With base and index set to the same value x, the scale codes give results 2x, 3x, 5x and 9x. With the base disabled, they give x, 2x, 4x and 8x.
- R11: `out_wr_en` is 1 exactly when `out_valid` is 1 and `out_fault` is 0. `out_wr_en` and `out_fault` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| src_is_reg | input | 1 | Source operand is a register (illegal form) |
| base_en | input | 1 | Base value takes part in the sum |
| base_val | input | 64 | Base register value |
| index_en | input | 1 | Index value takes part in the sum |
| index_val | input | 64 | Index register value |
| scale | input | 2 | Index shift amount |
| disp | input | 32 | Signed displacement |
| addr_size | input | 2 | Address width selector |
| reg_size | input | 2 | Destination width selector |
| out_valid | output | 1 | Result present |
| out_wr_en | output | 1 | Destination write enable |
| out_fault | output | 1 | Invalid-opcode fault |
| out_value | output | 64 | Value for the destination register |

## Verification
Some properties are checked on every cycle. These are the one-cycle latency, the exclusion between write and fault, and the zero value on a fault. Also checked every cycle: the fault for a register-form source, and the zero upper bits after a 16-bit destination or a 16-bit address. The actual address values are shown only by the bench scenarios. These cover wrap at each width, displacement sign extension, each scale code, the base-equals-index multipliers, and the truncate and zero-extend pairings, together with a reset applied in the middle of the run.

// File: rtl/eag_pkg.sv
// Package: shared constants and width-selector encoding for the effective
// address generator. Assumes a 64-bit datapath built from 16-bit lanes.
package eag_pkg;
    localparam int XLEN   = 64;
    localparam int DISP_W = 32;
    localparam int LANE_W = 16;
    localparam int LANES  = XLEN / LANE_W;
    localparam int CNT_W  = $clog2(LANES) + 1;

    typedef enum logic [1:0] {
        SZ_16  = 2'd0,
        SZ_32  = 2'd1,
        SZ_64  = 2'd2,
        SZ_BAD = 2'd3
    } size_e;
endpackage

// File: rtl/eag_size_decode.sv
// Module: turns a width selector into a count of active 16-bit lanes and a
// legality flag. Assumes the encoding in eag_pkg; code 3 is illegal.
module eag_size_decode
    import eag_pkg::*;
#(
    parameter int NLANES = LANES,
    parameter int CW     = CNT_W
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] lanes,
    output logic          legal
);
    // Purpose: map the selector to a lane count.
    always_comb begin
        legal = 1'b1;
        unique case (size_e'(sel))
            SZ_16:   lanes = CW'(1);
            SZ_32:   lanes = CW'(2);
            SZ_64:   lanes = CW'(NLANES);
            default: begin
                lanes = '0;
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/eag_addr_calc.sv
// Module: raw address sum base + (index << scale) + sext(disp) at full
// datapath width. Assumes wrap to the address width is applied downstream.
module eag_addr_calc
    import eag_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int DW = DISP_W
) (
    input  logic          base_en,
    input  logic [W-1:0]  base_val,
    input  logic          index_en,
    input  logic [W-1:0]  index_val,
    input  logic [1:0]    scale,
    input  logic [DW-1:0] disp,
    output logic [W-1:0]  sum
);
    logic [W-1:0] base_term;
    logic [W-1:0] index_term;
    logic [W-1:0] disp_term;

    // Purpose: gate the operands and form the three-term sum.
    always_comb begin
        base_term  = base_en  ? base_val : '0;
        index_term = index_en ? (index_val << scale) : '0;
        disp_term  = {{(W-DW){disp[DW-1]}}, disp};
        sum        = base_term + index_term + disp_term;
    end
endmodule

// File: rtl/eag_width_fit.sv
// Module: keeps the 16-bit lanes that lie inside both the address width and
// the register width and zeroes the rest. This gives wrap at the address
// width, truncation and zero-extension in one step. Assumes lane counts
// come from eag_size_decode.
module eag_width_fit
    import eag_pkg::*;
#(
    parameter int NLANES = LANES,
    parameter int LW     = LANE_W,
    parameter int CW     = CNT_W
) (
    input  logic [NLANES*LW-1:0] raw,
    input  logic [CW-1:0]        addr_lanes,
    input  logic [CW-1:0]        reg_lanes,
    output logic [NLANES*LW-1:0] fitted
);
    logic [CW-1:0] keep_lanes;

    // Purpose: the narrower of the two widths bounds the kept lanes.
    always_comb begin
        keep_lanes = (addr_lanes < reg_lanes) ? addr_lanes : reg_lanes;
    end

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        // Purpose: pass or clear one lane.
        always_comb begin
            fitted[g*LW +: LW] = (CW'(g) < keep_lanes) ? raw[g*LW +: LW] : '0;
        end
    end
endmodule

// File: rtl/eag_unit.sv
// Module: top of the effective address generator. Computes, fits and
// registers the address, or raises a fault for a register-form source or an
// illegal width selector. Assumes a synchronous active-low reset.
module eag_unit
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              src_is_reg,
    input  logic              base_en,
    input  logic [XLEN-1:0]   base_val,
    input  logic              index_en,
    input  logic [XLEN-1:0]   index_val,
    input  logic [1:0]        scale,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        addr_size,
    input  logic [1:0]        reg_size,
    output logic              out_valid,
    output logic              out_wr_en,
    output logic              out_fault,
    output logic [XLEN-1:0]   out_value
);
    logic [XLEN-1:0]  raw_sum;
    logic [XLEN-1:0]  fit_val;
    logic [CNT_W-1:0] a_lanes;
    logic [CNT_W-1:0] r_lanes;
    logic             a_legal;
    logic             r_legal;
    logic             fault_d;

    eag_addr_calc #(.W(XLEN), .DW(DISP_W)) calc_i (
        .base_en   (base_en),
        .base_val  (base_val),
        .index_en  (index_en),
        .index_val (index_val),
        .scale     (scale),
        .disp      (disp),
        .sum       (raw_sum)
    );

    eag_size_decode #(.NLANES(LANES), .CW(CNT_W)) adec_i (
        .sel   (addr_size),
        .lanes (a_lanes),
        .legal (a_legal)
    );

    eag_size_decode #(.NLANES(LANES), .CW(CNT_W)) rdec_i (
        .sel   (reg_size),
        .lanes (r_lanes),
        .legal (r_legal)
    );

    eag_width_fit #(.NLANES(LANES), .LW(LANE_W), .CW(CNT_W)) fit_i (
        .raw        (raw_sum),
        .addr_lanes (a_lanes),
        .reg_lanes  (r_lanes),
        .fitted     (fit_val)
    );

    // Purpose: decide whether this request is illegal.
    always_comb begin
        fault_d = src_is_reg | ~a_legal | ~r_legal;
    end

    // Purpose: result register with one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_wr_en <= 1'b0;
            out_fault <= 1'b0;
            out_value <= '0;
        end else begin
            out_valid <= in_valid;
            out_wr_en <= in_valid & ~fault_d;
            out_fault <= in_valid & fault_d;
            if (in_valid) begin
                out_value <= fault_d ? '0 : fit_val;
            end
        end
    end
endmodule

// File: rtl/eag_unit_chk.sv
// Module: property checker for eag_unit, attached by bind below.
module eag_unit_chk
    import eag_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            src_is_reg,
    input logic [1:0]      addr_size,
    input logic [1:0]      reg_size,
    input logic            out_valid,
    input logic            out_wr_en,
    input logic            out_fault,
    input logic [XLEN-1:0] out_value
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wr_en && !out_fault));
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_wr_en && out_fault));
    p_wr_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> out_valid);
    p_reg_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_is_reg) |=> (out_fault && !out_wr_en));
    p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_value == '0));
    p_bad_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (addr_size == 2'd3 || reg_size == 2'd3)) |=> out_fault);
    p_trunc16_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && reg_size == 2'd0) |=> (out_value[XLEN-1:16] == '0));
    p_zext16_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && addr_size == 2'd0) |=> (out_value[XLEN-1:16] == '0));
endmodule

bind eag_unit eag_unit_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .src_is_reg (src_is_reg),
    .addr_size  (addr_size),
    .reg_size   (reg_size),
    .out_valid  (out_valid),
    .out_wr_en  (out_wr_en),
    .out_fault  (out_fault),
    .out_value  (out_value)
);

// File: tb/eag_unit_tb.sv
module eag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        src_is_reg = 1'b0;
    logic        base_en = 1'b0;
    logic [63:0] base_val = '0;
    logic        index_en = 1'b0;
    logic [63:0] index_val = '0;
    logic [1:0]  scale = '0;
    logic [31:0] disp = '0;
    logic [1:0]  addr_size = '0;
    logic [1:0]  reg_size = '0;
    logic        out_valid;
    logic        out_wr_en;
    logic        out_fault;
    logic [63:0] out_value;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    eag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_is_reg(src_is_reg),
        .base_en(base_en), .base_val(base_val), .index_en(index_en),
        .index_val(index_val), .scale(scale), .disp(disp),
        .addr_size(addr_size), .reg_size(reg_size), .out_valid(out_valid),
        .out_wr_en(out_wr_en), .out_fault(out_fault), .out_value(out_value)
    );

    typedef struct packed {
        logic        srcreg;
        logic [1:0]  asz;
        logic [1:0]  rsz;
        logic        ben;
        logic        ien;
        logic [1:0]  scl;
        logic [63:0] base;
        logic [63:0] idx;
        logic [31:0] dsp;
        logic        xfault;
        logic [63:0] xval;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 2'd2, 64'h1000, 64'h10, 32'h8, 1'b0, 64'h1048},                            // R3 R5
        '{1'b0, 2'd1, 2'd1, 1'b1, 1'b0, 2'd0, 64'hFFFF_FFF0, 64'h0, 32'h20, 1'b0, 64'h10},                         // R3 wrap 32
        '{1'b0, 2'd2, 2'd0, 1'b1, 1'b0, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h0, 32'h0, 1'b0, 64'hDEF0},             // R6
        '{1'b0, 2'd0, 2'd2, 1'b1, 1'b0, 2'd0, 64'hFFFF, 64'h0, 32'hFFFF_FFFF, 1'b0, 64'hFFFE},                     // R7 R3
        '{1'b0, 2'd1, 2'd2, 1'b1, 1'b0, 2'd0, 64'h10, 64'h0, 32'hFFFF_FFE0, 1'b0, 64'hFFFF_FFF0},                  // R7
        '{1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 2'd3, 64'd7, 64'd7, 32'h0, 1'b0, 64'd63},                                 // R10 x9
        '{1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 2'd1, 64'd7, 64'd7, 32'h0, 1'b0, 64'd21},                                 // R10 x3
        '{1'b0, 2'd2, 2'd2, 1'b0, 1'b1, 2'd3, 64'd7, 64'd7, 32'h0, 1'b0, 64'd56},                                 // R4 x8
        '{1'b1, 2'd2, 2'd2, 1'b1, 1'b1, 2'd0, 64'd7, 64'd7, 32'h4, 1'b1, 64'd0},                                  // R8
        '{1'b0, 2'd3, 2'd2, 1'b1, 1'b0, 2'd0, 64'd5, 64'd0, 32'h0, 1'b1, 64'd0},                                  // R9
        '{1'b0, 2'd1, 2'd0, 1'b1, 1'b1, 2'd0, 64'd5, 64'd3, 32'h0, 1'b0, 64'd8},                                  // R4 R6
        '{1'b0, 2'd2, 2'd3, 1'b1, 1'b0, 2'd0, 64'd5, 64'd0, 32'h0, 1'b1, 64'd0}                                   // R9
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid   = 1'b1;
        src_is_reg = v.srcreg;
        addr_size  = v.asz;
        reg_size   = v.rsz;
        base_en    = v.ben;
        index_en   = v.ien;
        scale      = v.scl;
        base_val   = v.base;
        index_val  = v.idx;
        disp       = v.dsp;
    endtask

    // Watchdog: counts cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=<5000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state while in reset
        repeat (3) @(negedge clk);
        check("R1 valid", 64'(out_valid), 64'd0);
        check("R1 value", out_value, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {61'd0, out_valid, out_wr_en, out_fault}, 64'd0);

        // table walk: drive at negedge, result visible at the next negedge
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check($sformatf("R2 vec%0d valid", i), 64'(out_valid), 64'd1);
            check($sformatf("R8 R9 vec%0d fault", i), 64'(out_fault), 64'(VEC[i].xfault));
            check($sformatf("R11 vec%0d wr_en", i), 64'(out_wr_en), 64'(!VEC[i].xfault));
            check($sformatf("R3 vec%0d value", i), out_value, VEC[i].xval);
        end

        // R2: idle input gives no output activity
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 idle", {61'd0, out_valid, out_wr_en, out_fault}, 64'd0);

        // R10: remaining multipliers 2x, 5x with base==index; 4x with base off
        drive('{1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 2'd0, 64'd11, 64'd11, 32'h0, 1'b0, 64'd0});
        @(negedge clk);
        check("R10 x2", out_value, 64'd22);
        drive('{1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 2'd2, 64'd11, 64'd11, 32'h0, 1'b0, 64'd0});
        @(negedge clk);
        check("R10 x5", out_value, 64'd55);
        drive('{1'b0, 2'd2, 2'd2, 1'b0, 1'b1, 2'd2, 64'd11, 64'd11, 32'h0, 1'b0, 64'd0});
        @(negedge clk);
        check("R4 x4", out_value, 64'd44);

        // R5: 16/16 wrap and R3 64-bit wrap
        drive('{1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 2'd0, 64'hFFFF, 64'h2, 32'h0, 1'b0, 64'd0});
        @(negedge clk);
        check("R5 16 wrap", out_value, 64'h1);
        drive('{1'b0, 2'd2, 2'd2, 1'b1, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h2, 1'b0, 64'd0});
        @(negedge clk);
        check("R3 64 wrap", out_value, 64'h1);

        // R1: reset in mid-run clears a live result
        drive('{1'b0, 2'd2, 2'd2, 1'b1, 1'b0, 2'd0, 64'h55, 64'h0, 32'h0, 1'b0, 64'd0});
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", {60'd0, out_valid, out_wr_en, out_fault, |out_value}, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule